// File: doc/BRIEF.md
# NAND Bad-Block Marker Probe

This block decides whether one erase block of a raw NAND device is bad. Given a block number, it works out the first page of that block and reads one byte from that page. The byte sits at the column just past the main data area, which is the first spare byte. The block drives the command, address and data cycles on a simple strobe bus. It waits for the device's ready indication before fetching the byte, and it returns a bad/good verdict together with a single-cycle done pulse. A byte of exactly 0xFF means the block is good; any other value marks it bad.

Verdicts for the lowest-numbered blocks are kept in a small table. Every entry of the table holds the unknown code 0xFF after reset. A later request for a block whose verdict is already known is answered from the table, with no bus traffic. Blocks above the table range are probed on every request. Before each probe, the block pulses a clear of the pending status and keeps the error-correction disable asserted for the whole probe. Configuration inputs set pages per block, main-area size in bytes, and whether the row address takes two or three bytes.

Top module: `nand_bbm_probe`

## Requirements
- R1: After reset, `busy`, `done` and `nand_strobe` are low, and every table entry holds 0xFF (unknown), so the first request for any block issues a full probe.
- R2: A request is taken only while `busy` is low. `busy` rises on the cycle after acceptance and stays high through the cycle in which `done` pulses, then falls. `req_valid` is ignored while `busy` is high, and each accepted request gives exactly one `done` pulse.
- R3: Each probe starts with a one-cycle `stat_clr` pulse, followed on the next cycle by the first command strobe. `ecc_off` is high on every strobe cycle of the probe.
- R4: A probe issues strobes in this order, one per cycle: command 0x00, column low byte, column high byte, row low byte, row middle byte, an optional row high byte, command 0x30. After the wait, one data strobe follows. Encoding of `nand_kind`: 0 is a command, 1 is an address byte, 2 is a data read.
- R5: The row is pages-per-block × block number, sent least significant byte first. The column equals the configured main-area size, sent low byte first.
- R6: The row high byte is sent only when `cfg_two_row` is 0. When it is 1, command 0x30 directly follows the row middle byte.
- R7: After command 0x30, no strobe occurs until `nand_ready` is sampled high. The single data strobe then follows on the next cycle, and `nand_rdata` is sampled in that cycle.
- R8: On a probe, `verdict_bad` is 1 in the `done` cycle exactly when the sampled marker byte differs from 0xFF.
- R9: A request for a block below 16 whose table entry is known produces no strobe and no `stat_clr`. `done` pulses on the second cycle after acceptance, carrying the stored verdict.
- R10: A probe of a block below 16 stores its verdict in the table, and later requests for that block return it even if the device marker has since changed.
- R11: Blocks numbered 16 or higher are probed on every request, and their verdict follows the current device marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request to test a block |
| req_block | input | BLK_W | Block number of the request |
| cfg_pages_per_block | input | PPB_W | Pages in one erase block |
| cfg_main_bytes | input | COL_W | Main-area size in bytes (spare column) |
| cfg_two_row | input | 1 | 1: two row-address bytes, 0: three |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| verdict_bad | output | 1 | Block is bad; valid with `done` |
| ecc_off | output | 1 | Error correction disabled during the probe |
| stat_clr | output | 1 | Clear pending device status, one pulse per probe |
| nand_strobe | output | 1 | Bus cycle strobe |
| nand_kind | output | 2 | 0 command, 1 address, 2 data read |
| nand_wdata | output | 8 | Command or address byte |
| nand_rdata | input | 8 | Byte returned on a data strobe |
| nand_ready | input | 1 | Device ready/active indication |

## Verification
The assertions assume that `nand_rdata` is stable and valid in the data-strobe cycle. They also assume that the configuration inputs do not matter once a request has been taken, because the block latches them at acceptance. The bench model raises `nand_ready` only after command 0x30 and only after a random delay, and drops it on the data strobe. The bench changes configuration only between requests, and it injects a stray request only in the middle of a probe. Random requests cover blocks on both sides of the table boundary, several page and area sizes, and both row-address lengths.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int COL_BITS = 16;
  localparam int ROW_BITS = 24;
  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_START = 8'h30;
  localparam logic [7:0] CODE_UNKNOWN = 8'hFF;

  localparam logic [1:0] KIND_CMD  = 2'd0;
  localparam logic [1:0] KIND_ADDR = 2'd1;
  localparam logic [1:0] KIND_DATA = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_CLR, S_CMD0, S_COL_L, S_COL_H,
    S_ROW_L, S_ROW_M, S_ROW_H, S_CMD1, S_WAIT, S_READ, S_FIN
  } state_e;

  // first page of a block, truncated to the row-address width
  function automatic logic [ROW_BITS-1:0] first_page(input logic [31:0] ppb,
                                                      input logic [31:0] blk);
    logic [31:0] prod;
    prod = ppb * blk;
    return prod[ROW_BITS-1:0];
  endfunction

  function automatic logic marker_is_bad(input logic [7:0] b);
    return b != 8'hFF;
  endfunction
endpackage

// File: rtl/bbm_cache.sv
module bbm_cache #(
  parameter int CACHE_N = 16,
  localparam int IDX_W = $clog2(CACHE_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_code,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_code
);
  logic [7:0] mem [CACHE_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CACHE_N; i++) mem[i] <= bbm_pkg::CODE_UNKNOWN;
    end else if (we) begin
      mem[wr_idx] <= wr_code;
    end
  end

  assign rd_code = mem[rd_idx];
endmodule

// File: rtl/bbm_cycle_gen.sv
module bbm_cycle_gen
  import bbm_pkg::*;
(
  input  state_e                st,
  input  logic [COL_BITS-1:0]   col,
  input  logic [ROW_BITS-1:0]   row,
  output logic                  strobe,
  output logic [1:0]            kind,
  output logic [7:0]            wdata
);
  always_comb begin
    strobe = 1'b1;
    kind   = KIND_ADDR;
    wdata  = 8'h00;
    case (st)
      S_CMD0:  begin kind = KIND_CMD; wdata = CMD_READ;  end
      S_COL_L: wdata = col[7:0];
      S_COL_H: wdata = col[15:8];
      S_ROW_L: wdata = row[7:0];
      S_ROW_M: wdata = row[15:8];
      S_ROW_H: wdata = row[23:16];
      S_CMD1:  begin kind = KIND_CMD; wdata = CMD_START; end
      S_READ:  kind = KIND_DATA;
      default: begin strobe = 1'b0; kind = KIND_CMD; end
    endcase
  end
endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
  import bbm_pkg::*;
#(
  parameter int BLK_W   = 16,
  parameter int PPB_W   = 16,
  parameter int COL_W   = 16,
  parameter int CACHE_N = 16,
  localparam int IDX_W  = $clog2(CACHE_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [BLK_W-1:0]    req_block,
  input  logic [PPB_W-1:0]    cfg_ppb,
  input  logic [COL_W-1:0]    cfg_main,
  input  logic                cfg_two_row,
  input  logic                nand_ready,
  input  logic [7:0]          nand_rdata,
  input  logic [7:0]          cache_code,
  output state_e              st,
  output logic [COL_BITS-1:0] col_q,
  output logic [ROW_BITS-1:0] row_q,
  output logic [IDX_W-1:0]    cache_idx,
  output logic                cache_we,
  output logic [7:0]          cache_wcode,
  output logic                verdict_q,
  output logic                cache_hit
);
  logic [BLK_W-1:0] blk_q;
  logic             short_q;
  logic             in_range;

  assign in_range    = 32'(blk_q) < CACHE_N;
  assign cache_idx   = blk_q[IDX_W-1:0];
  assign cache_hit   = (st == S_LOOK) && in_range && (cache_code != CODE_UNKNOWN);
  assign cache_we    = (st == S_READ) && in_range;
  assign cache_wcode = {7'd0, marker_is_bad(nand_rdata)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      blk_q     <= '0;
      col_q     <= '0;
      row_q     <= '0;
      short_q   <= 1'b0;
      verdict_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          blk_q   <= req_block;
          col_q   <= COL_BITS'(cfg_main);
          row_q   <= first_page(32'(cfg_ppb), 32'(req_block));
          short_q <= cfg_two_row;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (cache_hit) begin
            verdict_q <= cache_code[0];
            st        <= S_FIN;
          end else begin
            st <= S_CLR;
          end
        end
        S_CLR:   st <= S_CMD0;
        S_CMD0:  st <= S_COL_L;
        S_COL_L: st <= S_COL_H;
        S_COL_H: st <= S_ROW_L;
        S_ROW_L: st <= S_ROW_M;
        S_ROW_M: st <= short_q ? S_CMD1 : S_ROW_H;
        S_ROW_H: st <= S_CMD1;
        S_CMD1:  st <= S_WAIT;
        S_WAIT:  if (nand_ready) st <= S_READ;
        S_READ: begin
          verdict_q <= marker_is_bad(nand_rdata);
          st        <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_bbm_probe.sv
module nand_bbm_probe
  import bbm_pkg::*;
#(
  parameter int BLK_W   = 16,
  parameter int PPB_W   = 16,
  parameter int COL_W   = 16,
  parameter int CACHE_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BLK_W-1:0] req_block,
  input  logic [PPB_W-1:0] cfg_pages_per_block,
  input  logic [COL_W-1:0] cfg_main_bytes,
  input  logic             cfg_two_row,
  output logic             busy,
  output logic             done,
  output logic             verdict_bad,
  output logic             ecc_off,
  output logic             stat_clr,
  output logic             nand_strobe,
  output logic [1:0]       nand_kind,
  output logic [7:0]       nand_wdata,
  input  logic [7:0]       nand_rdata,
  input  logic             nand_ready
);
  localparam int IDX_W = $clog2(CACHE_N);

  state_e              st;
  logic [COL_BITS-1:0] col_q;
  logic [ROW_BITS-1:0] row_q;
  logic [IDX_W-1:0]    cache_idx;
  logic                cache_we;
  logic [7:0]          cache_wcode;
  logic [7:0]          cache_code;
  logic                cache_hit;
  logic                marker_fetch;

  bbm_seq #(.BLK_W(BLK_W), .PPB_W(PPB_W), .COL_W(COL_W), .CACHE_N(CACHE_N)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
    .cfg_ppb(cfg_pages_per_block), .cfg_main(cfg_main_bytes), .cfg_two_row(cfg_two_row),
    .nand_ready(nand_ready), .nand_rdata(nand_rdata), .cache_code(cache_code),
    .st(st), .col_q(col_q), .row_q(row_q), .cache_idx(cache_idx),
    .cache_we(cache_we), .cache_wcode(cache_wcode), .verdict_q(verdict_bad),
    .cache_hit(cache_hit)
  );

  bbm_cache #(.CACHE_N(CACHE_N)) u_cache (
    .clk(clk), .rst_n(rst_n), .rd_idx(cache_idx), .rd_code(cache_code),
    .we(cache_we), .wr_idx(cache_idx), .wr_code(cache_wcode)
  );

  bbm_cycle_gen u_gen (
    .st(st), .col(col_q), .row(row_q),
    .strobe(nand_strobe), .kind(nand_kind), .wdata(nand_wdata)
  );

  assign busy         = st != S_IDLE;
  assign done         = st == S_FIN;
  assign stat_clr     = st == S_CLR;
  assign ecc_off      = st inside {S_CLR, S_CMD0, S_COL_L, S_COL_H, S_ROW_L,
                                   S_ROW_M, S_ROW_H, S_CMD1, S_WAIT, S_READ};
  assign marker_fetch = st == S_READ;
endmodule

// File: rtl/bbm_probe_chk.sv
module bbm_probe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       verdict_bad,
  input logic       ecc_off,
  input logic       stat_clr,
  input logic       nand_strobe,
  input logic [1:0] nand_kind,
  input logic [7:0] nand_wdata,
  input logic [7:0] nand_rdata,
  input logic       nand_ready,
  input logic       cache_hit,
  input logic       marker_fetch
);
  p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nand_strobe |-> busy);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
  p_done_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_clr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (nand_strobe && nand_kind == 2'd0 && nand_wdata == 8'h00));
  p_ecc_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nand_strobe |-> ecc_off);
  p_start_then_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_strobe && nand_kind == 2'd0 && nand_wdata == 8'h30) |=> !nand_strobe);
  p_data_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_strobe && nand_kind == 2'd2) |-> $past(nand_ready));
  p_fetch_is_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    marker_fetch |-> (nand_strobe && nand_kind == 2'd2));
  p_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_strobe && nand_kind == 2'd2) |=>
      (done && (verdict_bad == ($past(nand_rdata) != 8'hFF))));
  p_hit_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cache_hit |=> (done && !nand_strobe && !stat_clr));
endmodule

bind nand_bbm_probe bbm_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .verdict_bad(verdict_bad), .ecc_off(ecc_off), .stat_clr(stat_clr),
  .nand_strobe(nand_strobe), .nand_kind(nand_kind), .nand_wdata(nand_wdata),
  .nand_rdata(nand_rdata), .nand_ready(nand_ready), .cache_hit(cache_hit),
  .marker_fetch(marker_fetch)
);

// File: tb/tb_nand_bbm_probe.sv
`timescale 1ns/1ps
module tb_nand_bbm_probe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_block = '0;
  logic [15:0] cfg_ppb = 16'd64;
  logic [15:0] cfg_main = 16'd2048;
  logic        cfg_two_row = 1'b0;
  logic        busy, done, verdict_bad, ecc_off, stat_clr;
  logic        nand_strobe;
  logic [1:0]  nand_kind;
  logic [7:0]  nand_wdata;
  logic [7:0]  nand_rdata;
  logic        nand_ready = 1'b0;

  always #5 clk = ~clk;

  nand_bbm_probe dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
    .cfg_pages_per_block(cfg_ppb), .cfg_main_bytes(cfg_main), .cfg_two_row(cfg_two_row),
    .busy(busy), .done(done), .verdict_bad(verdict_bad), .ecc_off(ecc_off),
    .stat_clr(stat_clr), .nand_strobe(nand_strobe), .nand_kind(nand_kind),
    .nand_wdata(nand_wdata), .nand_rdata(nand_rdata), .nand_ready(nand_ready)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] markers [0:255];
  logic [7:0] bcache [0:15];
  int cur_blk = 0;
  logic [9:0] log_q [0:15];
  int log_n = 0;
  int clr_n = 0;
  int done_n = 0;
  int ecc_err = 0;
  int rdy_wait = 0;
  logic arm = 1'b0;

  assign nand_rdata = markers[cur_blk[7:0]];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor and device model, all at the falling edge
  always @(negedge clk) begin
    if (stat_clr) clr_n++;
    if (done) done_n++;
    if (nand_strobe) begin
      if (!ecc_off) ecc_err++;
      if (log_n < 16) log_q[log_n] = {nand_kind, nand_wdata};
      log_n++;
      if (nand_kind == 2'd0 && nand_wdata == 8'h30) begin
        arm = 1'b1;
        rdy_wait = int'($urandom % 6);
      end
      if (nand_kind == 2'd2) nand_ready = 1'b0;
    end else if (arm) begin
      if (rdy_wait == 0) begin
        nand_ready = 1'b1;
        arm = 1'b0;
      end else rdy_wait--;
    end
  end

  task automatic do_req(input int blk, input int ppb, input int msz,
                        input bit two_row, input bit poke);
    logic [9:0] exp_log [0:15];
    int exp_n;
    bit hit, exp_bad;
    int cyc;
    longint row;
    hit = (blk < 16) && (bcache[blk] != 8'hFF);
    row = longint'(ppb) * longint'(blk);
    if (hit) begin
      exp_bad = bcache[blk][0];
      exp_n = 0;
    end else begin
      exp_bad = markers[blk] != 8'hFF;
      exp_log[0] = {2'd0, 8'h00};
      exp_log[1] = {2'd1, 8'(msz)};
      exp_log[2] = {2'd1, 8'(msz >> 8)};
      exp_log[3] = {2'd1, 8'(row)};
      exp_log[4] = {2'd1, 8'(row >> 8)};
      exp_n = 5;
      if (!two_row) begin exp_log[5] = {2'd1, 8'(row >> 16)}; exp_n = 6; end
      exp_log[exp_n] = {2'd0, 8'h30};
      exp_log[exp_n+1] = {2'd2, 8'h00};
      exp_n += 2;
      if (blk < 16) bcache[blk] = {7'd0, exp_bad};
    end
    @(negedge clk);
    log_n = 0; clr_n = 0; done_n = 0; ecc_err = 0;
    cur_blk = blk;
    cfg_ppb = 16'(ppb); cfg_main = 16'(msz); cfg_two_row = two_row;
    req_block = 16'(blk); req_valid = 1'b1;
    chk(!busy, "R2 idle before request", busy, 0);
    @(negedge clk);
    cyc = 1;
    while (!done && cyc < 400) begin
      req_valid = poke && (cyc == 3);
      if (req_valid) req_block = 16'(blk ^ 1);
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(done, "R2 done pulse seen", done, 1);
    chk(busy, "R2 busy during done", busy, 1);
    chk(verdict_bad == exp_bad, hit ? "R10 cached verdict" : (blk >= 16 ? "R11 probe verdict" : "R8 probe verdict"),
        verdict_bad, exp_bad);
    if (hit) chk(cyc == 2, "R9 hit latency", cyc, 2);
    chk(log_n == exp_n, hit ? "R9 no bus access on hit" : "R4 strobe count", log_n, exp_n);
    if (log_n == exp_n) begin
      for (int i = 0; i < exp_n; i++)
        chk(log_q[i] == exp_log[i], two_row ? "R6 cycle content" : "R5 cycle content",
            log_q[i], exp_log[i]);
    end
    chk(clr_n == (hit ? 0 : 1), "R3 status clear count", clr_n, hit ? 0 : 1);
    chk(ecc_err == 0, "R3 ecc off on strobes", ecc_err, 0);
    repeat (3) @(negedge clk);
    chk(done_n == 1 && !busy, "R2 single done then idle", done_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++)
      markers[i] = ($urandom % 3 == 0) ? 8'($urandom % 255) : 8'hFF;
    for (int i = 0; i < 16; i++) bcache[i] = 8'hFF;
    markers[3] = 8'h00; markers[4] = 8'hFF; markers[20] = 8'h7E;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !nand_strobe, "R1 reset outputs", {busy, done, nand_strobe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !nand_strobe, "R1 idle after reset", {busy, done, nand_strobe}, 0);
    // R1: first request to block 3 must be a full probe
    do_req(3, 64, 2048, 1'b0, 1'b0);
    // R10: marker changes, cached bad verdict still returned
    markers[3] = 8'hFF;
    do_req(3, 64, 2048, 1'b0, 1'b0);
    // R6: two-row addressing on a good block, then hit
    do_req(4, 128, 4096, 1'b1, 1'b0);
    do_req(4, 128, 4096, 1'b1, 1'b0);
    // R11: block beyond the table, marker flips between requests
    do_req(20, 256, 8192, 1'b0, 1'b0);
    markers[20] = 8'hFF;
    do_req(20, 256, 8192, 1'b0, 1'b0);
    // R2: stray request during a probe is ignored
    do_req(9, 32, 512, 1'b0, 1'b1);
    // R5: large row reaching the high byte, boundary block 15 and 16
    do_req(15, 16'hFFFF, 16'hABCD, 1'b0, 1'b0);
    do_req(16, 1024, 2112, 1'b0, 1'b0);
    for (int n = 0; n < 60; n++) begin
      int b, p, m;
      b = int'($urandom % 40);
      case ($urandom % 4)
        0: p = 32; 1: p = 64; 2: p = 128; default: p = 256;
      endcase
      case ($urandom % 4)
        0: m = 512; 1: m = 2048; 2: m = 4096; default: m = 8192;
      endcase
      do_req(b, p, m, 1'($urandom % 2), 1'($urandom % 4 == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule